// File: doc/BRIEF.md
# Shadowed 8-bit PWM Generator

This block makes one pulse-width-modulated waveform from an 8-bit up-counter and hands it out to several driver channels. The counter steps once per prescaler tick. The prescaler is a divider with a fixed ratio followed by a divider set by software, so one PWM period lasts 256 ticks. The duty setting is copied into a shadow register each time the counter passes through zero. The comparator works only from that copy, so a duty write never changes a period that is already running.

A mask holds one enable bit per driver channel. A channel whose bit is set receives the raw PWM waveform. A channel whose bit is clear receives a constant 1, which means "not PWM controlled": its driver then follows its own static control, and this is the only way to get full-on drive. While every mask bit is 0, the whole generator stays idle with its prescaler and counter cleared. It restarts from count zero as soon as any bit is set.

The configuration inputs are meant to be driven straight from register flops elsewhere in the chip. The reset input is asynchronous and active low. It is released to the logic through a two-flop synchronizer.

Top module: `pwm8_shadow_gen`

## Requirements
- R1: The counter is 8 bits wide. It steps 0,1,…,255 and then back to 0, one step per tick, so the PWM period is 256·T clock cycles, where T is the tick length.
- R2: T = FIX_DIV·(freq_cfg+1) clock cycles. The fixed ratio FIX_DIV is a parameter with default 80, and freq_cfg ranges from 0 to 255.
- R3: Each time the counter wraps to 0, and at a restart, the new duty value is loaded. If that value is nonzero, pwm_raw goes high in that same cycle; if it is 0, pwm_raw stays low.
- R4: duty_cfg is sampled only at a wrap or a restart. A write made during a period leaves the high time of that period unchanged and sets the high time of the next period.
- R5: With a loaded duty d, pwm_raw is high for exactly d·T cycles and then low for (256−d)·T cycles. d=0 gives a constant low. d=255 gives a low time of exactly T, so the output is never high for a whole period.
- R6: While drv_en is all zeros, pwm_raw is 0 and the prescaler and counter are held at 0. On the first clock edge at which drv_en is nonzero, the generator restarts at count 0, and pwm_raw is high after that edge if duty_cfg is nonzero.
- R7: drv_ctrl[i] equals pwm_raw when drv_en[i] is 1 and is a constant 1 when drv_en[i] is 0.
- R8: A new freq_cfg is taken only when a tick completes. The tick in progress keeps its old length, and the ticks after it use the new length.
- R9: While rst_n is low, pwm_raw is 0 whatever the other inputs are. The internal reset is released on the second rising clock edge after rst_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_cfg | input | 8 | Programmable prescaler setting; tick = FIX_DIV·(freq_cfg+1) cycles |
| duty_cfg | input | 8 | Duty setting in 1/256 of a period, shadowed at every wrap |
| drv_en | input | NUM_CH | Per-channel PWM enable mask; all zeros idles the generator |
| pwm_raw | output | 1 | Raw PWM waveform |
| drv_ctrl | output | NUM_CH | Per-channel control: PWM when enabled, else constant 1 |

## Verification
High and low times are measured in clock cycles for several combinations of duty and frequency setting: a half duty, a quarter duty at a slower prescale, the maximum duty and zero duty. Together these separate a wrong tick length, an off-by-one in the compare and a wrong zero-duty behaviour. A duty written just after a rising edge and a frequency change made inside a running tick show that reloads happen only at the wrap and at the tick boundary: the current period or tick keeps its old values, and the next one shows the new ones. Mask patterns that enable, partly enable and then clear the channels show the per-channel gating, the idle hold and the restart from zero.

// File: rtl/pwm8_pkg.sv
package pwm8_pkg;
  // event that decides the core's next state in a cycle
  typedef enum logic [1:0] {
    EV_IDLE  = 2'd0,
    EV_START = 2'd1,
    EV_STEP  = 2'd2,
    EV_HOLD  = 2'd3
  } core_ev_e;
endpackage

// File: rtl/pwm8_rst_sync.sv
module pwm8_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/pwm8_presc.sv
module pwm8_presc #(
  parameter int FIX_DIV = 80,
  parameter int CFG_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CFG_W-1:0] freq_cfg,
  output logic             tick
);
  localparam int FW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  localparam logic [FW-1:0] FIX_LAST = FW'(FIX_DIV - 1);

  logic [FW-1:0]    fcnt_q, fcnt_d;
  logic [CFG_W-1:0] pcnt_q, pcnt_d;
  logic [CFG_W-1:0] lim_q, lim_d;
  logic             ftick;

  assign ftick = (fcnt_q == FIX_LAST);
  assign tick  = go && ftick && (pcnt_q == lim_q);

  always_comb begin
    fcnt_d = fcnt_q;
    pcnt_d = pcnt_q;
    lim_d  = lim_q;
    if (!go) begin
      fcnt_d = '0;
      pcnt_d = '0;
      lim_d  = freq_cfg;
    end else begin
      fcnt_d = ftick ? '0 : FW'(fcnt_q + 1'b1);
      if (ftick) begin
        if (pcnt_q == lim_q) begin
          pcnt_d = '0;
          lim_d  = freq_cfg;
        end else begin
          pcnt_d = CFG_W'(pcnt_q + 1'b1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt_q <= '0;
      pcnt_q <= '0;
      lim_q  <= '0;
    end else begin
      fcnt_q <= fcnt_d;
      pcnt_q <= pcnt_d;
      lim_q  <= lim_d;
    end
  end

  // R8: the limit in use changes only when a tick completes
  a_r8_limit_held: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !tick) |=> $stable(lim_q));

  // R2: the programmable stage never runs past its limit
  a_r2_pcnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (pcnt_q <= lim_q));
endmodule

// File: rtl/pwm8_core.sv
module pwm8_core
  import pwm8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             start,
  input  logic             tick,
  input  logic [CNT_W-1:0] duty_cfg,
  output logic             pwm
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic             pwm_q, pwm_d;
  logic [CNT_W-1:0] cnt_inc;
  core_ev_e         ev;

  assign cnt_inc = CNT_W'(cnt_q + 1'b1);

  always_comb begin
    if (start)           ev = EV_START;
    else if (!go)        ev = EV_IDLE;
    else if (tick)       ev = EV_STEP;
    else                 ev = EV_HOLD;
  end

  always_comb begin
    cnt_d    = cnt_q;
    shadow_d = shadow_q;
    pwm_d    = pwm_q;
    case (ev)
      EV_IDLE: begin
        cnt_d = '0;
        pwm_d = 1'b0;
      end
      EV_START: begin
        cnt_d    = '0;
        shadow_d = duty_cfg;
        pwm_d    = (duty_cfg != '0);
      end
      EV_STEP: begin
        cnt_d = cnt_inc;
        if (cnt_q == CNT_MAX) begin
          shadow_d = duty_cfg;
          pwm_d    = (duty_cfg != '0);
        end else if (cnt_inc == shadow_q) begin
          pwm_d = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      shadow_q <= '0;
      pwm_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      shadow_q <= shadow_d;
      pwm_q    <= pwm_d;
    end
  end

  assign pwm = pwm_q;

  // R1: the counter returns to zero after its top value
  a_r1_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (go && tick && cnt_q == CNT_MAX) |=> (cnt_q == '0));

  // R4: the shadow copy moves only at a wrap
  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !(tick && cnt_q == CNT_MAX)) |=> $stable(shadow_q));

  // R5: while running, the output is high exactly while the count is below the shadow duty
  a_r5_compare: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (pwm_q == (cnt_q < shadow_q)));

  // R3: a zero duty never raises the output
  a_r3_zero_duty_low: assert property (@(posedge clk) disable iff (!rst_n)
    (go && shadow_q == '0) |-> !pwm_q);
endmodule

// File: rtl/pwm8_shadow_gen.sv
module pwm8_shadow_gen #(
  parameter int FIX_DIV = 80,
  parameter int CNT_W   = 8,
  parameter int CFG_W   = 8,
  parameter int NUM_CH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  freq_cfg,
  input  logic [CNT_W-1:0]  duty_cfg,
  input  logic [NUM_CH-1:0] drv_en,
  output logic              pwm_raw,
  output logic [NUM_CH-1:0] drv_ctrl
);
  logic srst_n;
  logic active;
  logic run_q, run_d;
  logic go, start, tick;

  pwm8_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  assign active = |drv_en;
  assign run_d  = active;
  assign go     = active && run_q;
  assign start  = active && !run_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) run_q <= 1'b0;
    else         run_q <= run_d;
  end

  pwm8_presc #(
    .FIX_DIV (FIX_DIV),
    .CFG_W   (CFG_W)
  ) u_presc (
    .clk      (clk),
    .rst_n    (srst_n),
    .go       (go),
    .freq_cfg (freq_cfg),
    .tick     (tick)
  );

  pwm8_core #(
    .CNT_W (CNT_W)
  ) u_core (
    .clk      (clk),
    .rst_n    (srst_n),
    .go       (go),
    .start    (start),
    .tick     (tick),
    .duty_cfg (duty_cfg),
    .pwm      (pwm_raw)
  );

  // R7: per-channel gating, constant 1 when the channel is not PWM controlled
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign drv_ctrl[i] = drv_en[i] ? pwm_raw : 1'b1;
  end

  // R6: an idle generator keeps its output low
  a_r6_idle_low: assert property (@(posedge clk) disable iff (!srst_n)
    !run_q |-> !pwm_raw);

  // R6: a restart begins with a high output when the duty is nonzero
  a_r6_restart_high: assert property (@(posedge clk) disable iff (!srst_n)
    (start && duty_cfg != '0) |=> pwm_raw);

  // R9: asynchronous reset forces the output low
  a_r9_reset_low: assert property (@(posedge clk)
    !rst_n |-> !pwm_raw);
endmodule

// File: tb/sim_pwm8_shadow_gen.sv
module sim_pwm8_shadow_gen;
  localparam int CLK_P  = 10;
  localparam int FIXD   = 3;
  localparam int NCH    = 4;
  localparam int WD_MAX = 200000;

  logic           clk;
  logic           rst_n;
  logic [7:0]     freq_cfg;
  logic [7:0]     duty_cfg;
  logic [NCH-1:0] drv_en;
  logic           pwm_raw;
  logic [NCH-1:0] drv_ctrl;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  pwm8_shadow_gen #(.FIX_DIV(FIXD), .NUM_CH(NCH)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .freq_cfg (freq_cfg),
    .duty_cfg (duty_cfg),
    .drv_en   (drv_en),
    .pwm_raw  (pwm_raw),
    .drv_ctrl (drv_ctrl)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WD_MAX) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp<%0d", cyc, WD_MAX);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // counts the high and low cycles of the next complete period
  task automatic measure(output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (pwm_raw !== 1'b0 && g < 60000) begin @(negedge clk); g++; end
    while (pwm_raw !== 1'b1 && g < 60000) begin @(negedge clk); g++; end
    while (pwm_raw === 1'b1 && g < 60000) begin hi++; @(negedge clk); g++; end
    while (pwm_raw === 1'b0 && g < 60000) begin lo++; @(negedge clk); g++; end
  endtask

  task automatic wait_rise();
    int g = 0;
    while (pwm_raw !== 1'b0 && g < 60000) begin @(negedge clk); g++; end
    while (pwm_raw !== 1'b1 && g < 60000) begin @(negedge clk); g++; end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; freq_cfg = 8'd0; duty_cfg = 8'd50; drv_en = 4'b0011;
    repeat (3) @(negedge clk);
    chk("R9 pwm low in reset", pwm_raw, 0);
    chk("R7 gating in reset", drv_ctrl, 4'b1100);
    drv_en = 4'b0000;
    @(negedge clk);
    chk("R7 all channels static", drv_ctrl, 4'b1111);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_idle();
    int seen = 0;
    duty_cfg = 8'd100;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (pwm_raw) seen++;
    end
    chk("R6 idle output stays low", seen, 0);
  endtask

  task automatic t_start_half();
    int hi, lo;
    freq_cfg = 8'd0; duty_cfg = 8'd128;
    drv_en = 4'b0001;
    chk("R6 still low before edge", pwm_raw, 0);
    @(negedge clk);
    chk("R6 R3 high right after enable", pwm_raw, 1);
    measure(hi, lo);
    chk("R5 half duty high", hi, 128*FIXD);
    chk("R1 half duty low", lo, 128*FIXD);
  endtask

  task automatic t_slow_quarter();
    int hi, lo;
    freq_cfg = 8'd2; duty_cfg = 8'd64;
    measure(hi, lo);
    measure(hi, lo);
    chk("R2 quarter duty high at F=2", hi, 64*FIXD*3);
    chk("R1 R2 period at F=2", hi + lo, 256*FIXD*3);
  endtask

  task automatic t_max_duty();
    int hi, lo;
    freq_cfg = 8'd0; duty_cfg = 8'd255;
    measure(hi, lo);
    measure(hi, lo);
    chk("R5 max duty high", hi, 255*FIXD);
    chk("R5 max duty low is one tick", lo, FIXD);
  endtask

  task automatic t_zero_duty();
    int seen = 0;
    duty_cfg = 8'd0;
    repeat (2*256*FIXD) @(negedge clk);
    for (int i = 0; i < 2*256*FIXD; i++) begin
      @(negedge clk);
      if (pwm_raw) seen++;
    end
    chk("R3 R5 zero duty stays low", seen, 0);
  endtask

  task automatic t_mid_duty();
    int hi, lo;
    duty_cfg = 8'd64;
    measure(hi, lo);
    wait_rise();
    hi = 1;
    duty_cfg = 8'd200;
    @(negedge clk);
    while (pwm_raw === 1'b1 && hi < 2000) begin hi++; @(negedge clk); end
    chk("R4 running period keeps old duty", hi, 64*FIXD);
    measure(hi, lo);
    chk("R4 next period uses new duty", hi, 200*FIXD);
  endtask

  task automatic t_freq_mid_tick();
    int hi, lo;
    freq_cfg = 8'd0; duty_cfg = 8'd1;
    measure(hi, lo);
    wait_rise();
    hi = 1;
    freq_cfg = 8'd5;
    @(negedge clk);
    while (pwm_raw === 1'b1 && hi < 2000) begin hi++; @(negedge clk); end
    lo = 0;
    while (pwm_raw === 1'b0 && lo < 20000) begin lo++; @(negedge clk); end
    chk("R8 current tick keeps old length", hi, FIXD);
    chk("R8 later ticks use new length", lo, 255*FIXD*6);
    measure(hi, lo);
    chk("R2 one tick at F=5", hi, FIXD*6);
  endtask

  task automatic t_gating();
    freq_cfg = 8'd0; duty_cfg = 8'd128;
    drv_en = 4'b0101;
    wait_rise();
    @(negedge clk);
    chk("R7 gating while high", drv_ctrl, 4'b1111);
    while (pwm_raw === 1'b1) @(negedge clk);
    chk("R7 gating while low", drv_ctrl, 4'b1010);
    wait_rise();
    drv_en = 4'b0000;
    @(negedge clk);
    chk("R6 output drops when mask clears", pwm_raw, 0);
    chk("R7 cleared mask gives static level", drv_ctrl, 4'b1111);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_start_half();
    t_slow_quarter();
    t_max_duty();
    t_zero_duty();
    t_mid_duty();
    t_freq_mid_tick();
    t_gating();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule